// File: doc/BRIEF.md
# Eight-Channel Conversion Start and Soft-Reset Controller

This block sits between a small 16-bit host register bus and eight output channels. Each channel holds a 128-sample FIFO, an 8-bit control byte and a conversion-pending delay counter. Word 0 of the register space carries two byte lanes: a write-only high byte that soft-resets channels, and a low byte that requests conversion starts on a write and returns the per-channel FIFO-full flags on a read. Each channel also has its own control-byte word and its own FIFO write port.

A conversion can be started in two ways. Software can set the channel's start bit, unless the control byte selects external-trigger-only mode. Alternatively, a falling edge on the channel's active-low trigger input can start it, if external triggering is enabled. The conversion itself takes place a fixed 6.625 us later. That delay is counted in clock cycles, and the cycle count is derived from a clock-frequency parameter. When the delay ends, the channel emits a one-cycle conversion pulse and pops the oldest FIFO sample onto its data output.

A FIFO write that arrives while the FIFO is full is refused: the sample is not stored and the bus access gets no acknowledge. The same applies to accesses to unused addresses.

Top module: `chan_start_ctrl`

## Requirements
- R1: After hardware reset, every FIFO level is 0, every full flag and conversion pulse is 0, and every control byte reads 0.
- R2: A write to word 0 with lane 1 enabled soft-resets channel c when data bit 8+c is 1. This clears that channel's control byte, its pending delay, its FIFO level and its full flag, and no other channel is affected. Within the same write, a soft reset of a channel takes priority over a start request for that channel.
- R3: A write to word 0 with lane 0 enabled requests a start on channel c when data bit c is 1. conv_go[c] then goes high for exactly one cycle, exactly DELAY = floor(CLK_MHZ*6625/1000) cycles after the clock edge that accepts the request. DELAY is 1656 at 250 MHz.
- R4: When control bits 2:1 of a channel equal 2'b11 (external-trigger-only), a software start request for that channel has no effect.
- R5: When control bit 3 is 1, a falling edge on trig_n[c] starts channel c within DELAY+4 cycles, after passing through a two-flop synchronizer. When control bit 3 is 0, the trigger input is ignored.
- R6: A start request that arrives while a delay is already pending is ignored. The pending conversion keeps its original time and fires only once.
- R7: A read of word 0 returns the full flags of channels 7..0 in bits 7..0 and zero in bits 15..8. A flag is 1 exactly when its FIFO holds 128 samples.
- R8: A write to a full channel FIFO is not stored and is not acknowledged.
- R9: Word 0 is the start/reset/full word. Channel c uses word 4+2c for its control byte (bits 7..0, readable and writable) and word 5+2c for its FIFO write port. Any other word, and any read of a FIFO port, produces no acknowledge. A hit is acknowledged on the cycle after the request.
- R10: Byte lanes are honoured: with only lane 1 enabled, no start takes place; with only lane 0 enabled, no soft reset takes place.
- R11: At each conversion pulse, the oldest FIFO sample appears on that channel's conv_data slice, with conv_dvld high, in write order. If the FIFO is empty, the pulse still occurs and conv_dvld is 0.
- R12: fifo_level[8c+7:8c] gives the current sample count of channel c, from 0 to 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address |
| bus_be | input | 2 | Byte-lane enables (bit 1 = bits 15..8) |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | Acknowledge, one cycle after an accepted request |
| bus_rdata | output | 16 | Read data, valid with bus_ack |
| trig_n | input | 8 | Active-low external trigger per channel |
| conv_go | output | 8 | One-cycle conversion pulse per channel |
| conv_dvld | output | 8 | Sample on conv_data is valid with conv_go |
| conv_data | output | 128 | 16-bit sample per channel, channel c at bits 16c+15..16c |
| fifo_level | output | 64 | 8-bit FIFO occupancy per channel |

## Verification
Conversion starts are tried in four ways: a plain software start, a second start during a pending delay, a software start in external-trigger-only mode, and a trigger-input falling edge with the enable bit both set and clear. The exact pulse cycle separates a correct delay count from one that is off by one. Each pulse is scored against a per-channel queue of expected samples, so pop order, empty-FIFO pulses and stray pulses are told apart. Single-lane writes, a soft reset during a pending delay, a combined soft-reset-and-start write, and a fill to 128 followed by one refused write show reset isolation, lane gating and the full boundary.

// File: rtl/chan_start_pkg.sv
package chan_start_pkg;

  // Trigger mode held in control bits 2:1
  typedef enum logic [1:0] {
    TM_SOFT_A   = 2'b00,
    TM_SOFT_B   = 2'b01,
    TM_SOFT_C   = 2'b10,
    TM_EXT_ONLY = 2'b11
  } trig_mode_e;

  localparam int CTL_MODE_LO = 1;
  localparam int CTL_EXT_EN  = 3;

  // 6.625 us expressed in clock cycles
  function automatic int start_delay_cycles(input int clk_mhz);
    return (clk_mhz * 6625) / 1000;
  endfunction

endpackage

// File: rtl/trig_edge.sv
module trig_edge (
  input  logic clk,
  input  logic rst,
  input  logic trig_n,
  output logic fall
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[1:0], trig_n};
  end

  assign fall = sh[2] & ~sh[1];
endmodule

// File: rtl/chan_fifo.sv
module chan_fifo #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 128,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] rd_q;
  logic          push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & (level != '0) & ~clr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
    rd_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdata = rd_q;

  // R8: a refused push leaves occupancy untouched
  a_r8_full_hold: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr) |=> (level == $past(level)));

  // R12: occupancy never exceeds the depth
  a_r12_level_bound: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
endmodule

// File: rtl/chan_ctrl.sv
module chan_ctrl
  import chan_start_pkg::*;
#(
  parameter  int DW    = 16,
  parameter  int DEPTH = 128,
  parameter  int DELAY = 1656,
  localparam int CW    = $clog2(DELAY + 1),
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          srst,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wd,
  input  logic          sw_start,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          trig_n,
  output logic [7:0]    ctrl_q,
  output logic          full,
  output logic [LW-1:0] level,
  output logic          go,
  output logic          dvld,
  output logic [DW-1:0] data
);
  logic          ext_fall, pending, start_req, pop;
  logic [CW-1:0] cnt;
  trig_mode_e    mode;

  trig_edge u_edge (.clk(clk), .rst(rst), .trig_n(trig_n), .fall(ext_fall));

  assign mode      = trig_mode_e'(ctrl_q[CTL_MODE_LO +: 2]);
  assign start_req = (sw_start && mode != TM_EXT_ONLY) ||
                     (ext_fall && ctrl_q[CTL_EXT_EN]);
  assign pop       = pending && (cnt == '0) && !srst;

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      ctrl_q  <= '0;
      pending <= 1'b0;
      cnt     <= '0;
      go      <= 1'b0;
      dvld    <= 1'b0;
    end else begin
      go   <= 1'b0;
      dvld <= 1'b0;
      if (ctrl_we) ctrl_q <= ctrl_wd;
      if (pending) begin
        if (cnt == '0) begin
          pending <= 1'b0;
          go      <= 1'b1;
          dvld    <= (level != '0);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start_req) begin
        pending <= 1'b1;
        cnt     <= CW'(DELAY - 1);
      end
    end
  end

  chan_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(srst), .push(push), .wdata(push_data),
    .pop(pop), .rdata(data), .level(level), .full(full)
  );

  // R2: soft reset leaves the channel idle and empty
  a_r2_srst_clears: assert property (@(posedge clk) disable iff (rst)
    srst |=> (ctrl_q == '0 && !pending && level == '0 && !go));

  // R3: conversion pulse lasts one cycle
  a_r3_go_one_cycle: assert property (@(posedge clk) disable iff (rst)
    go |=> !go);

  // R4: software start ignored in external-trigger-only mode
  a_r4_ext_only_blocks: assert property (@(posedge clk) disable iff (rst)
    (sw_start && mode == TM_EXT_ONLY && !pending && !srst &&
     !(ext_fall && ctrl_q[CTL_EXT_EN])) |=> !pending);

  // R6: a pending delay keeps counting regardless of new requests
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (pending && cnt != '0 && !srst) |=> (pending && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/chan_start_ctrl.sv
module chan_start_ctrl
  import chan_start_pkg::*;
#(
  parameter  int NUM_CH  = 8,    // 2..8: full flags share one byte
  parameter  int DW      = 16,
  parameter  int DEPTH   = 128,
  parameter  int CLK_MHZ = 250,
  parameter  int ADDR_W  = 6,
  localparam int DELAY   = start_delay_cycles(CLK_MHZ),
  localparam int LW      = $clog2(DEPTH) + 1,
  localparam int CW      = $clog2(NUM_CH),
  localparam int CH_BASE = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_be,
  input  logic [15:0]          bus_wdata,
  output logic                 bus_ack,
  output logic [15:0]          bus_rdata,
  input  logic [NUM_CH-1:0]    trig_n,
  output logic [NUM_CH-1:0]    conv_go,
  output logic [NUM_CH-1:0]    conv_dvld,
  output logic [NUM_CH*DW-1:0] conv_data,
  output logic [NUM_CH*LW-1:0] fifo_level
);
  logic [ADDR_W-1:0] off;
  logic              is_w0, in_ch, is_ctl, is_fifo, hit, refuse, wr_w0;
  logic [CW-1:0]     ch_idx;
  logic [NUM_CH-1:0] full_v;
  logic [7:0]        ctrl_arr [NUM_CH];
  logic [7:0]        full_byte;
  logic [15:0]       rd_mux;

  always_comb begin
    off     = bus_addr - ADDR_W'(CH_BASE);
    is_w0   = (bus_addr == '0);
    in_ch   = (off < ADDR_W'(2 * NUM_CH));
    is_ctl  = in_ch & ~off[0];
    is_fifo = in_ch & off[0];
    ch_idx  = off[CW:1];
    hit     = is_w0 | is_ctl | (is_fifo & bus_we);
    refuse  = is_fifo & bus_we & full_v[ch_idx];
    wr_w0   = bus_req & bus_we & is_w0;
    full_byte = '0;
    full_byte[NUM_CH-1:0] = full_v;
    if (is_w0)       rd_mux = {8'h00, full_byte};
    else if (is_ctl) rd_mux = {8'h00, ctrl_arr[ch_idx]};
    else             rd_mux = '0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic srst_c, start_c, ctl_we_c, push_c;
    assign srst_c   = wr_w0 & bus_be[1] & bus_wdata[8+c];
    assign start_c  = wr_w0 & bus_be[0] & bus_wdata[c];
    assign ctl_we_c = bus_req & bus_we & is_ctl & bus_be[0] & (ch_idx == CW'(c));
    assign push_c   = bus_req & bus_we & is_fifo & (ch_idx == CW'(c));

    chan_ctrl #(.DW(DW), .DEPTH(DEPTH), .DELAY(DELAY)) u_chan (
      .clk(clk), .rst(rst), .srst(srst_c),
      .ctrl_we(ctl_we_c), .ctrl_wd(bus_wdata[7:0]),
      .sw_start(start_c), .push(push_c), .push_data(bus_wdata),
      .trig_n(trig_n[c]),
      .ctrl_q(ctrl_arr[c]), .full(full_v[c]),
      .level(fifo_level[c*LW +: LW]),
      .go(conv_go[c]), .dvld(conv_dvld[c]),
      .data(conv_data[c*DW +: DW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= bus_req & hit & ~refuse;
      if (bus_req && !bus_we) bus_rdata <= rd_mux;
    end
  end

  // R9: unmapped words are never answered
  a_r9_unused_no_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !is_w0 && !in_ch) |=> !bus_ack);

  // R9: FIFO ports do not answer reads
  a_r9_fifo_read_no_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && is_fifo) |=> !bus_ack);
endmodule

// File: tb/sim_chan_start_ctrl.sv
module sim_chan_start_ctrl;
  localparam int NCH = 8;
  localparam int DLY = 1656;

  logic         clk = 1'b0;
  logic         rst;
  logic         bus_req, bus_we;
  logic [5:0]   bus_addr;
  logic [1:0]   bus_be;
  logic [15:0]  bus_wdata;
  logic         bus_ack;
  logic [15:0]  bus_rdata;
  logic [7:0]   trig_n;
  logic [7:0]   conv_go, conv_dvld;
  logic [127:0] conv_data;
  logic [63:0]  fifo_level;

  always #2 clk = ~clk;

  chan_start_ctrl u0 (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .trig_n(trig_n),
    .conv_go(conv_go), .conv_dvld(conv_dvld), .conv_data(conv_data),
    .fifo_level(fifo_level)
  );

  int    checks = 0, errors = 0;
  bit    done = 0;
  string ctx = "R1";

  typedef struct packed { logic [2:0] ch; logic vld; logic [15:0] data; } exp_t;
  exp_t expq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lvl(input int c);
    return int'(fifo_level[c*8 +: 8]);
  endfunction

  task automatic bus_op(input bit we, input int addr, input logic [1:0] be,
                        input logic [15:0] wd, output bit ack, output logic [15:0] rd);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = 6'(addr); bus_be = be; bus_wdata = wd;
    @(negedge clk);
    ack = bus_ack; rd = bus_rdata;
    bus_req = 0; bus_we = 0;
  endtask

  task automatic wr(input int addr, input logic [1:0] be, input logic [15:0] wd, output bit ack);
    logic [15:0] rd;
    bus_op(1, addr, be, wd, ack, rd);
  endtask

  task automatic rdw(input int addr, output bit ack, output logic [15:0] rd);
    bus_op(0, addr, 2'b11, 16'h0, ack, rd);
  endtask

  // driver side of the scoreboard
  task automatic expect_conv(input int c, input bit vld, input logic [15:0] d);
    exp_t e;
    e.ch = 3'(c); e.vld = vld; e.data = d;
    expq.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas(input int c, output int k);
    k = 0;
    while (!conv_go[c] && k < 5000) begin
      @(negedge clk);
      k++;
    end
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++) begin
        if (conv_go[c]) begin
          int idx = -1;
          for (int i = 0; i < expq.size(); i++)
            if (idx < 0 && expq[i].ch == 3'(c)) idx = i;
          if (idx < 0) begin
            chk(0, {ctx, " unexpected conversion"}, c, -1);
          end else begin
            chk(conv_dvld[c] == expq[idx].vld, "R11 dvld", conv_dvld[c], expq[idx].vld);
            if (expq[idx].vld)
              chk(conv_data[c*16 +: 16] == expq[idx].data, "R11 data",
                  conv_data[c*16 +: 16], expq[idx].data);
            expq.delete(idx);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [15:0] rd;
    int k, nack;

    rst = 1; bus_req = 0; bus_we = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
    trig_n = '1;
    repeat (4) @(negedge clk);
    rst = 0;

    // R1 reset state
    rdw(0, ack, rd);
    chk(ack && rd == 16'h0, "R1 full flags", rd, 0);
    chk(fifo_level == 64'h0, "R1 levels", lvl(0), 0);
    chk(conv_go == 8'h0, "R1 go", conv_go, 0);
    rdw(4 + 2*3, ack, rd);
    chk(ack && rd == 16'h0, "R1 ctrl3", rd, 0);

    // R3 / R11 / R12 basic start on ch0
    ctx = "R3";
    wr(5, 2'b11, 16'hA001, ack); chk(ack, "R12 push ack", ack, 1);
    wr(5, 2'b11, 16'hA002, ack);
    wr(5, 2'b11, 16'hA003, ack);
    chk(lvl(0) == 3, "R12 level ch0", lvl(0), 3);
    expect_conv(0, 1, 16'hA001);
    wr(0, 2'b01, 16'h0001, ack);
    meas(0, k);
    chk(k == DLY, "R3 delay", k, DLY);
    idle(1);
    chk(conv_go[0] == 1'b0, "R3 single cycle", conv_go[0], 0);
    chk(lvl(0) == 2, "R11 pop level", lvl(0), 2);

    // R6 restart during pending delay
    ctx = "R6";
    expect_conv(0, 1, 16'hA002);
    wr(0, 2'b01, 16'h0001, ack);
    idle(100);
    wr(0, 2'b01, 16'h0001, ack);
    meas(0, k);
    chk(k + 102 == DLY, "R6 original time", k + 102, DLY);
    idle(DLY + 50);
    chk(lvl(0) == 1, "R6 one pop only", lvl(0), 1);

    // R4 external-only mode blocks software start
    ctx = "R4";
    wr(4 + 2*1, 2'b01, 16'h0006, ack);
    wr(5 + 2*1, 2'b11, 16'h1111, ack);
    wr(0, 2'b01, 16'h0002, ack);
    idle(DLY + 100);
    chk(lvl(1) == 1, "R4 no pop", lvl(1), 1);
    wr(4 + 2*1, 2'b01, 16'h0000, ack);
    expect_conv(1, 1, 16'h1111);
    wr(0, 2'b01, 16'h0002, ack);
    meas(1, k);
    chk(k == DLY, "R4 soft mode starts", k, DLY);

    // R5 external trigger, enabled on ch2 (empty FIFO), disabled on ch3
    ctx = "R5";
    wr(4 + 2*2, 2'b01, 16'h0008, ack);
    wr(4 + 2*3, 2'b01, 16'h0000, ack);
    expect_conv(2, 0, 16'h0);
    @(negedge clk); trig_n[2] = 0; trig_n[3] = 0;
    meas(2, k);
    chk(k >= DLY && k <= DLY + 4, "R5 trigger start", k, DLY);
    idle(DLY + 50);
    trig_n = '1;

    // R10 byte lanes
    ctx = "R10";
    wr(5 + 2*4, 2'b11, 16'h4444, ack);
    wr(0, 2'b10, 16'h0010, ack);
    chk(ack, "R10 lane1 ack", ack, 1);
    idle(DLY + 50);
    chk(lvl(4) == 1, "R10 no start via lane1", lvl(4), 1);
    wr(0, 2'b01, 16'h1000, ack);
    chk(lvl(4) == 1, "R10 no reset via lane0", lvl(4), 1);

    // R2 soft reset isolation and priority
    ctx = "R2";
    wr(4 + 2*5, 2'b01, 16'h000A, ack);
    rdw(4 + 2*5, ack, rd);
    chk(ack && rd == 16'h000A, "R9 ctrl readback", rd, 16'h000A);
    wr(5 + 2*5, 2'b11, 16'h5551, ack);
    wr(5 + 2*5, 2'b11, 16'h5552, ack);
    wr(4 + 2*6, 2'b01, 16'h0004, ack);
    wr(5 + 2*6, 2'b11, 16'h6661, ack);
    wr(0, 2'b01, 16'h0020, ack);
    idle(10);
    wr(0, 2'b10, 16'h2000, ack);
    chk(lvl(5) == 0, "R2 level cleared", lvl(5), 0);
    rdw(4 + 2*5, ack, rd);
    chk(rd == 16'h0, "R2 ctrl cleared", rd, 0);
    rdw(4 + 2*6, ack, rd);
    chk(rd == 16'h0004, "R2 neighbour ctrl kept", rd, 4);
    chk(lvl(6) == 1, "R2 neighbour level kept", lvl(6), 1);
    idle(DLY + 50);
    wr(0, 2'b11, 16'h4040, ack);
    idle(DLY + 50);
    chk(lvl(6) == 0, "R2 reset beats start", lvl(6), 0);

    // R7 / R8 full boundary on ch7
    ctx = "R8";
    nack = 0;
    for (int i = 0; i < 128; i++) begin
      wr(5 + 2*7, 2'b11, 16'h7000 + 16'(i), ack);
      if (ack) nack++;
    end
    chk(nack == 128, "R8 fill acks", nack, 128);
    chk(lvl(7) == 128, "R12 level full", lvl(7), 128);
    rdw(0, ack, rd);
    chk(rd == 16'h0080, "R7 full flag", rd, 16'h0080);
    wr(5 + 2*7, 2'b11, 16'hDEAD, ack);
    chk(!ack, "R8 refused ack", ack, 0);
    chk(lvl(7) == 128, "R8 not stored", lvl(7), 128);
    expect_conv(7, 1, 16'h7000);
    wr(0, 2'b01, 16'h0080, ack);
    meas(7, k);
    chk(k == DLY, "R3 delay ch7", k, DLY);
    idle(2);
    rdw(0, ack, rd);
    chk(rd == 16'h0, "R7 flag clears", rd, 0);
    wr(5 + 2*7, 2'b11, 16'h7777, ack);
    rdw(0, ack, rd);
    chk(rd == 16'h0080, "R7 full again", rd, 16'h0080);
    wr(0, 2'b10, 16'h8000, ack);
    rdw(0, ack, rd);
    chk(rd == 16'h0, "R2 full cleared by soft reset", rd, 0);

    // R9 decode
    ctx = "R9";
    rdw(2, ack, rd);
    chk(!ack, "R9 unused read", ack, 0);
    rdw(5, ack, rd);
    chk(!ack, "R9 fifo port read", ack, 0);
    wr(40, 2'b11, 16'h1234, ack);
    chk(!ack, "R9 unused write", ack, 0);
    rdw(4 + 2*1, ack, rd);
    chk(ack && rd == 16'h0, "R9 ctrl read", rd, 0);

    idle(20);
    chk(expq.size() == 0, "R11 all conversions seen", expq.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule